// File: doc/BRIEF.md
# Polynomial-Selectable Parallel CRC Engine

This block computes a CRC remainder over one message word. It can use any of ten generator polynomials, all held in the hardware at the same time. A 4-bit code picks the polynomial when a word begins, and no reconfiguration is needed to change it.

The word is 32 bits wide and enters as a run of 8-bit slices, so a word takes four accepted slices. For every polynomial there is a combinational modulo-2 network that folds one slice into the current remainder. All ten networks have the same input and output widths. A tree of 2-way multiplexers, steered by the latched select, therefore feeds a single shared remainder register.

Width, slice width, word width, polynomial count and polynomial values are all parameters. A small configuration with generator x^4+x^3+1, 4-bit slices and 4-bit words uses the same structure and serves as a self-test setting.

Top module: `poly_crc_engine`

## Requirements
- R1: While reset is held and right after it, `crc` is zero, and `done` and `sel_err` are low.
- R2: A cycle with `start` high and a legal `poly_sel` does four things: it clears `crc` to zero, latches the select, arms the engine for a new word, and lowers `sel_err`. A slice offered in that same cycle is not accepted.
- R3: Each accepted slice updates the remainder as a bit-serial register would, taking the slice bits most-significant first. For each bit b: feedback f = crc[W-1] xor b, then crc = (crc << 1) xor (f ? P : 0). P holds the coefficients x^(W-1)..x^0, and x^W is implied. The remainder starts from zero and is not reflected or inverted.
- R4: Select codes 0 to 9 choose, in this order, the polynomials FA8FC37F, F6D15C19, DACEC37F, A39431B7, F76D83AD, 8A6C8B65, 93A5A6DD, A58B5D9B, C7DCACA5 and C7A9CF8D.
- R5: The slices of a word are taken most-significant slice first. Four slices make a word. `done` is high for exactly one cycle: the cycle after the edge that accepts the fourth slice. The final remainder is visible on `crc` in that same cycle.
- R6: After a word is complete, further valid slices are ignored, and `crc` holds its value until the next `start`.
- R7: Cycles with `din_valid` low between slices leave the remainder and the slice count unchanged.
- R8: A `start` with a select code of 10 to 15 raises `sel_err`, which stays high until the next `start`. It leaves `crc` unchanged, and no slices are accepted until a legal `start`.
- R9: Changes on `poly_sel` after the `start` cycle do not affect the word in progress.
- R10: With 4-bit width, 4-bit slices, 4-bit words and polynomial 9 (x^4+x^3+1), one slice completes a word, and the result follows the R3 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a word: clear the remainder and latch the select |
| poly_sel | input | 4 | Polynomial code, sampled on `start` |
| din | input | 8 | Message slice |
| din_valid | input | 1 | `din` carries a slice this cycle |
| crc | output | 32 | Remainder register |
| done | output | 1 | One-cycle pulse when a word completes |
| sel_err | output | 1 | Last `start` carried an illegal select code |

## Verification
On every cycle, assertions check the following: `done` is a single-cycle pulse and follows an accepted slice; a legal start clears the remainder; an illegal start raises the error flag and leaves the remainder untouched; and the remainder holds whenever the engine is idle. Whether the XOR networks and the select tree give the right remainder for each polynomial can only be shown by the bench scenarios. These compare random, all-zero and all-one words against a bit-serial model, and also cover slice gaps, select changes mid-word, the start-cycle slice, and the small x^4+x^3+1 configuration.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;
  localparam int POLY_COUNT = 10;
  localparam int POLY_WIDTH = 32;
  // Entry i sits at bits [i*32 +: 32]; code 0 is the lowest field.
  localparam logic [POLY_COUNT*POLY_WIDTH-1:0] DEFAULT_POLYS = {
    32'hC7A9CF8D, 32'hC7DCACA5, 32'hA58B5D9B, 32'h93A5A6DD, 32'h8A6C8B65,
    32'hF76D83AD, 32'hA39431B7, 32'hDACEC37F, 32'hF6D15C19, 32'hFA8FC37F
  };
endpackage

// File: rtl/crc_xor_array.sv
module crc_xor_array #(
  parameter int CRC_W   = 32,
  parameter int SLICE_W = 8,
  parameter logic [CRC_W-1:0] POLY = '0
) (
  input  logic [CRC_W-1:0]   cur,
  input  logic [SLICE_W-1:0] slice,
  output logic [CRC_W-1:0]   nxt
);
  // Unrolled bit-serial division; synthesis flattens it into an XOR network.
  function automatic logic [CRC_W-1:0] fold_slice(input logic [CRC_W-1:0] r,
                                                  input logic [SLICE_W-1:0] d);
    logic [CRC_W-1:0] t;
    logic             fb;
    t = r;
    for (int i = SLICE_W - 1; i >= 0; i--) begin
      fb = t[CRC_W-1] ^ d[i];
      t  = (t << 1) ^ (fb ? POLY : '0);
    end
    return t;
  endfunction

  assign nxt = fold_slice(cur, slice);
endmodule

// File: rtl/crc_mux_tree.sv
module crc_mux_tree #(
  parameter int W     = 32,
  parameter int N     = 10,
  parameter int SEL_W = 4
) (
  input  logic [N*W-1:0]   leaves,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     out
);
  localparam int LEAVES = 1 << SEL_W;
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node 0 is the root, leaves start at LEAVES-1.
  logic [W-1:0] node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[LEAVES-1+i] = leaves[i*W +: W];
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  // The leaf level is steered by sel[0], which pairs code 2k with 2k+1.
  for (genvar lvl = 0; lvl < SEL_W; lvl++) begin : g_lvl
    for (genvar p = 0; p < (1 << lvl); p++) begin : g_node
      assign node[(1<<lvl)-1+p] = sel[SEL_W-1-lvl] ? node[(1<<(lvl+1))-1+2*p+1]
                                                   : node[(1<<(lvl+1))-1+2*p];
    end
  end

  assign out = node[0];
endmodule

// File: rtl/poly_crc_engine.sv
module poly_crc_engine #(
  parameter int CRC_W   = 32,
  parameter int SLICE_W = 8,
  parameter int WORD_W  = 32,
  parameter int NPOLY   = crc_sel_pkg::POLY_COUNT,
  parameter int SEL_W   = 4,
  parameter logic [NPOLY*CRC_W-1:0] POLYS = crc_sel_pkg::DEFAULT_POLYS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SEL_W-1:0]   poly_sel,
  input  logic [SLICE_W-1:0] din,
  input  logic               din_valid,
  output logic [CRC_W-1:0]   crc,
  output logic               done,
  output logic               sel_err
);
  localparam int SLICES = WORD_W / SLICE_W;
  localparam int CNT_W  = (SLICES > 1) ? $clog2(SLICES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SLICES - 1);
  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NPOLY);

  logic [CRC_W-1:0] crc_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, err_q;

  // Candidate next remainders, one per polynomial.
  logic [NPOLY*CRC_W-1:0] cand;
  logic [CRC_W-1:0]       picked;

  for (genvar g = 0; g < NPOLY; g++) begin : g_arr
    crc_xor_array #(
      .CRC_W  (CRC_W),
      .SLICE_W(SLICE_W),
      .POLY   (POLYS[g*CRC_W +: CRC_W])
    ) u_arr (
      .cur  (crc_q),
      .slice(din),
      .nxt  (cand[g*CRC_W +: CRC_W])
    );
  end

  crc_mux_tree #(.W(CRC_W), .N(NPOLY), .SEL_W(SEL_W)) u_tree (
    .leaves(cand),
    .sel   (sel_q),
    .out   (picked)
  );

  // Named events, shared by the control logic and the assertions.
  logic sel_legal, slice_take, word_end, start_ok, start_bad;
  assign sel_legal  = poly_sel < SEL_LIMIT;
  assign slice_take = busy_q && din_valid && !start;
  assign word_end   = slice_take && (cnt_q == LAST_CNT);
  assign start_ok   = start && sel_legal;
  assign start_bad  = start && !sel_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= '0;
      sel_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= word_end;
      if (start) begin
        err_q  <= !sel_legal;
        cnt_q  <= '0;
        busy_q <= sel_legal;
        if (sel_legal) begin
          crc_q <= '0;
          sel_q <= poly_sel;
        end
      end else if (slice_take) begin
        crc_q <= picked;
        if (word_end) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign crc     = crc_q;
  assign done    = done_q;
  assign sel_err = err_q;

  // Assertions
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_slice_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(din_valid && busy_q && !start));
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (crc == '0) && !sel_err);
  p_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> sel_err && $stable(crc));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy_q) |=> $stable(crc));
  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !din_valid) |=> $stable(crc) && !done);
endmodule

// File: tb/sim_poly_crc_engine.sv
module sim_poly_crc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  poly_sel = '0;
  logic [7:0]  din = '0;
  logic        din_valid = 1'b0;
  logic [31:0] crc;
  logic        done, sel_err;

  logic        s_start = 1'b0;
  logic [3:0]  s_sel = '0;
  logic [3:0]  s_din = '0;
  logic        s_valid = 1'b0;
  logic [3:0]  s_crc;
  logic        s_done, s_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  poly_crc_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .poly_sel(poly_sel),
    .din(din), .din_valid(din_valid), .crc(crc), .done(done), .sel_err(sel_err)
  );

  poly_crc_engine #(
    .CRC_W(4), .SLICE_W(4), .WORD_W(4), .NPOLY(10), .SEL_W(4),
    .POLYS({10{4'h9}})
  ) u1 (
    .clk(clk), .rst_n(rst_n), .start(s_start), .poly_sel(s_sel),
    .din(s_din), .din_valid(s_valid), .crc(s_crc), .done(s_done), .sel_err(s_err)
  );

  logic [31:0] plist [10] = '{32'hFA8FC37F, 32'hF6D15C19, 32'hDACEC37F,
    32'hA39431B7, 32'hF76D83AD, 32'h8A6C8B65, 32'h93A5A6DD, 32'hA58B5D9B,
    32'hC7DCACA5, 32'hC7A9CF8D};

  // Plain shift register: message bits shifted in, then w zero bits.
  function automatic logic [31:0] serial_crc(input logic [31:0] poly,
      input logic [31:0] msg, input int w, input int nbits);
    logic [31:0] r, mask;
    logic        top;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    r = '0;
    for (int i = nbits + w - 1; i >= 0; i--) begin
      top = r[w-1];
      r = ((r << 1) | ((i >= w) ? 32'(msg[i-w]) : 32'd0)) & mask;
      if (top) r = r ^ (poly & mask);
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // Every task starts and ends at a falling edge.
  task automatic do_start(input logic [3:0] code, input logic v, input logic [7:0] d);
    start = 1'b1; poly_sel = code; din_valid = v; din = d;
    @(negedge clk);
    start = 1'b0; din_valid = 1'b0;
  endtask

  task automatic feed(input logic [7:0] d);
    din = d; din_valid = 1'b1;
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic run_word(input logic [3:0] code, input logic [31:0] w, input string tag);
    logic [31:0] exp;
    exp = serial_crc(plist[code], w, 32, 32);
    do_start(code, 1'b0, 8'h00);
    for (int s = 3; s >= 0; s--) feed(w[s*8 +: 8]);
    check(done === 1'b1, {tag, " done"}, 32'(done), 32'd1);
    check(crc === exp, tag, crc, exp);
    @(negedge clk);
    check(done === 1'b0, {tag, " done width"}, 32'(done), 32'd0);
  endtask

  initial begin
    logic [31:0] w, exp, held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(crc === 32'd0 && done === 1'b0 && sel_err === 1'b0, "R1 reset",
          {crc[31:3], done, sel_err, 1'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(crc === 32'd0 && done === 1'b0, "R1 after reset", crc, 32'd0);

    // R3 R4 R5: each code, random, zero and one words
    for (int c = 0; c < 10; c++) begin
      run_word(4'(c), $urandom(), "R4 random");
      run_word(4'(c), 32'h0000_0000, "R3 zeros");
      run_word(4'(c), 32'hFFFF_FFFF, "R3 ones");
    end

    // R7: idle cycles between slices
    w = $urandom();
    exp = serial_crc(plist[5], w, 32, 32);
    do_start(4'd5, 1'b0, 8'h00);
    for (int s = 3; s >= 0; s--) begin
      feed(w[s*8 +: 8]);
      if (s != 0) begin
        @(negedge clk);
        @(negedge clk);
        check(done === 1'b0, "R7 no early done", 32'(done), 32'd0);
      end
    end
    check(done === 1'b1 && crc === exp, "R7 gapped word", crc, exp);

    // R6: slices after completion are ignored
    held = crc;
    feed(8'hA5);
    feed(8'h3C);
    check(crc === held && done === 1'b0, "R6 hold after word", crc, held);

    // R2: start clears; slice in start cycle ignored
    do_start(4'd1, 1'b1, 8'hFF);
    check(crc === 32'd0, "R2 cleared", crc, 32'd0);
    w = 32'h1234_5678;
    exp = serial_crc(plist[1], w, 32, 32);
    for (int s = 3; s >= 0; s--) feed(w[s*8 +: 8]);
    check(crc === exp && done === 1'b1, "R2 start slice ignored", crc, exp);

    // R9: select changes mid-word
    w = $urandom();
    exp = serial_crc(plist[3], w, 32, 32);
    do_start(4'd3, 1'b0, 8'h00);
    for (int s = 3; s >= 0; s--) begin
      poly_sel = 4'(7 + s);
      feed(w[s*8 +: 8]);
    end
    check(crc === exp, "R9 latched select", crc, exp);

    // R8: illegal code
    @(negedge clk);
    held = crc;
    do_start(4'd12, 1'b0, 8'h00);
    check(sel_err === 1'b1, "R8 flag", 32'(sel_err), 32'd1);
    check(crc === held, "R8 crc kept", crc, held);
    for (int s = 0; s < 4; s++) feed(8'h5A);
    check(crc === held && done === 1'b0, "R8 no slices taken", crc, held);
    check(sel_err === 1'b1, "R8 flag held", 32'(sel_err), 32'd1);
    do_start(4'd15, 1'b0, 8'h00);
    check(sel_err === 1'b1 && crc === held, "R8 code 15", crc, held);
    do_start(4'd0, 1'b0, 8'h00);
    check(sel_err === 1'b0 && crc === 32'd0, "R8 cleared by legal start", crc, 32'd0);

    // R10: small x^4+x^3+1 configuration, 4-bit slices
    for (int m = 0; m < 16; m++) begin
      s_start = 1'b1; s_sel = 4'd0;
      @(negedge clk);
      s_start = 1'b0; s_din = 4'(m); s_valid = 1'b1;
      @(negedge clk);
      s_valid = 1'b0;
      exp = serial_crc(32'h9, 32'(m), 4, 4);
      check(s_done === 1'b1 && {28'd0, s_crc} === exp, "R10 small config",
            {28'd0, s_crc}, exp);
    end

    finish_run();
  end
endmodule